// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block collects eight interrupt request lines into one interrupt output for a processor. Each line has a request bit, an in-service bit and a mask bit. Requests are latched on a rising edge of the line (edge mode) or follow the line level (level mode), and one configuration bit selects the mode for all lines. A fixed priority, where line 0 ranks highest, picks the winning request. The output is raised only when the winner outranks every line already in service.

The processor answers with two active-low acknowledge strobes. The first strobe freezes the choice of line. The second strobe returns an 8-bit vector that joins a programmable base field with the number of the winning line, and it moves that line from pending to in-service. An end-of-interrupt command retires the highest-priority line in service. If nothing is pending when the first strobe arrives, the block returns the line 7 vector and marks no line as in service.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every line is masked, no request or in-service bit is set, edge mode is selected, the base field is 0, and `intr_o`, `vec_valid_o` and `vec_o` are 0.
- R2: In edge mode a low-to-high transition on a line sets its request bit. A line that stays high after its request has been acknowledged does not set the request again until it falls and rises.
- R3: In level mode a request bit is set while its line is high and clear while its line is low.
- R4: A masked line never raises `intr_o`, and `intr_o` is low while all mask bits are 1. An unmasked pending line with nothing in service raises `intr_o`.
- R5: Among unmasked pending lines, the lowest-numbered line wins.
- R6: A pending line raises `intr_o` only if its number is strictly lower than that of every line in service.
- R7: The first falling edge of `inta_ni` freezes the selected line, so requests that arrive later do not change the vector. `vec_valid_o` rises one clock after the second falling edge is sampled, and it falls one clock after `inta_ni` is sampled high.
- R8: The vector has the base field in bits [7:3] and the line number in bits [2:0] (000 for line 0 up to 111 for line 7).
- R9: Acknowledging a line sets its in-service bit and clears its request bit, so `intr_o` drops for that line.
- R10: A one-cycle `eoi_i` clears the in-service bit of the lowest-numbered line that is in service.
- R11: If no line can be presented at the first acknowledge edge, the vector carries line number 7 and no in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines |
| mode_we_i | input | 1 | Write strobe for the trigger mode |
| mode_level_i | input | 1 | Trigger mode to write: 1 selects level, 0 selects edge |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 8 | Mask value to write; a 1 masks that line |
| base_we_i | input | 1 | Write strobe for the vector base |
| base_wdata_i | input | 5 | Vector base to write |
| eoi_i | input | 1 | End-of-interrupt command, one cycle |
| inta_ni | input | 1 | Acknowledge strobe, active low |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector byte |
| vec_valid_o | output | 1 | Vector byte valid |

## Verification
The assertions assume that `inta_ni` is synchronous to `clk_i` and holds each level for at least one clock. They also assume that `eoi_i` is not raised in a cycle where an acknowledge edge is sampled, because an in-service bit set in that cycle would hide the bit that the command clears. The bench drives every input on the falling clock edge and holds each acknowledge phase for a full cycle. It sends end-of-interrupt commands only while the strobe is high, so the stimulus stays inside these assumptions.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic {
    ACK_IDLE  = 1'b0,
    ACK_ARMED = 1'b1
  } ack_st_e;
endpackage

// File: rtl/vic_req_bank.sv
module vic_req_bank #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 level_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] irr_o
);
  logic [NUM_LINES-1:0] irq_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic rise;
    assign rise = irq_i[g] & ~irq_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q[g] <= 1'b0;
        irr_o[g] <= 1'b0;
      end else begin
        irq_q[g] <= irq_i[g];
        if (level_i) irr_o[g] <= irq_i[g] & ~clr_i[g];
        else         irr_o[g] <= (irr_o[g] | rise) & ~clr_i[g];
      end
    end
  end
endmodule

// File: rtl/vic_find_first.sv
module vic_find_first #(
  parameter int W   = 8,
  parameter int IDW = $clog2(W)
) (
  input  logic [W-1:0]   req_i,
  output logic           vld_o,
  output logic [IDW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int BASE_W    = VEC_W - $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 mode_we_i,
  input  logic                 mode_level_i,
  input  logic                 mask_we_i,
  input  logic [NUM_LINES-1:0] mask_wdata_i,
  input  logic                 base_we_i,
  input  logic [BASE_W-1:0]    base_wdata_i,
  input  logic                 eoi_i,
  input  logic                 inta_ni,
  output logic                 intr_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o
);
  import vic_pkg::*;

  localparam int IDW = $clog2(NUM_LINES);

  logic                 level_q;
  logic [NUM_LINES-1:0] mask_q, isr_q, irr_q, pend;
  logic [NUM_LINES-1:0] ack_set, eoi_clr;
  logic [BASE_W-1:0]    base_q;
  logic                 pend_vld, isr_vld, present;
  logic [IDW-1:0]       pend_idx, isr_idx, sel_idx;
  logic                 sel_real, inta_q, inta_fall;
  ack_st_e              ack_st;
  logic [VEC_W-1:0]     vec_q;
  logic                 vld_q;

  vic_req_bank #(.NUM_LINES(NUM_LINES)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .level_i(level_q),
    .clr_i  (ack_set),
    .irr_o  (irr_q)
  );

  assign pend = irr_q & ~mask_q;

  vic_find_first #(.W(NUM_LINES), .IDW(IDW)) u_ff_pend (
    .req_i(pend), .vld_o(pend_vld), .idx_o(pend_idx)
  );

  vic_find_first #(.W(NUM_LINES), .IDW(IDW)) u_ff_isr (
    .req_i(isr_q), .vld_o(isr_vld), .idx_o(isr_idx)
  );

  assign present   = pend_vld && (!isr_vld || (pend_idx < isr_idx));
  assign intr_o    = present;
  assign inta_fall = inta_q & ~inta_ni;

  always_comb begin
    ack_set = '0;
    eoi_clr = '0;
    if (ack_st == ACK_ARMED && inta_fall && sel_real) ack_set[sel_idx] = 1'b1;
    if (eoi_i && isr_vld)                             eoi_clr[isr_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      mask_q  <= '1;
      base_q  <= '0;
      isr_q   <= '0;
    end else begin
      if (mode_we_i) level_q <= mode_level_i;
      if (mask_we_i) mask_q  <= mask_wdata_i;
      if (base_we_i) base_q  <= base_wdata_i;
      isr_q <= (isr_q | ack_set) & ~eoi_clr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inta_q   <= 1'b1;
      ack_st   <= ACK_IDLE;
      sel_idx  <= '0;
      sel_real <= 1'b0;
      vec_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      inta_q <= inta_ni;
      if (inta_ni) vld_q <= 1'b0;
      if (inta_fall) begin
        if (ack_st == ACK_IDLE) begin
          // freeze the choice; nothing presentable means spurious
          ack_st   <= ACK_ARMED;
          sel_real <= present;
          sel_idx  <= present ? pend_idx : '1;
        end else begin
          ack_st <= ACK_IDLE;
          vec_q  <= {base_q, sel_idx};
          vld_q  <= 1'b1;
        end
      end
    end
  end

  assign vec_o       = vec_q;
  assign vec_valid_o = vld_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int BASE_W    = VEC_W - $clog2(NUM_LINES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 inta_ni,
  input logic                 eoi_i,
  input logic                 intr_o,
  input logic                 vec_valid_o,
  input logic [VEC_W-1:0]     vec_o,
  input logic [BASE_W-1:0]    base_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] isr_q
);
  localparam int IDW = VEC_W - BASE_W;

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !intr_o); // R4

  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && inta_ni) |=> !vec_valid_o); // R7

  AST_VEC_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> (vec_o[VEC_W-1:IDW] == $past(base_q))); // R8

  AST_EOI_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && (isr_q != '0) && inta_ni) |=> ($countones(isr_q) < $past($countones(isr_q)))); // R10
endmodule

bind vec_irq_ctrl vic_chk #(
  .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .BASE_W(BASE_W)
) u_vic_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .inta_ni    (inta_ni),
  .eoi_i      (eoi_i),
  .intr_o     (intr_o),
  .vec_valid_o(vec_valid_o),
  .vec_o      (vec_o),
  .base_q     (base_q),
  .mask_q     (mask_q),
  .isr_q      (isr_q)
);

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_i = '0;
  logic       mode_we_i = 1'b0, mode_level_i = 1'b0;
  logic       mask_we_i = 1'b0;
  logic [7:0] mask_wdata_i = '0;
  logic       base_we_i = 1'b0;
  logic [4:0] base_wdata_i = '0;
  logic       eoi_i = 1'b0, inta_ni = 1'b1;
  logic       intr_o, vec_valid_o;
  logic [7:0] vec_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  vec_irq_ctrl dut (.*);

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [7:0] m);
    mask_we_i = 1'b1; mask_wdata_i = m; step(); mask_we_i = 1'b0;
  endtask

  task automatic wr_base(input logic [4:0] b);
    base_we_i = 1'b1; base_wdata_i = b; step(); base_we_i = 1'b0;
  endtask

  task automatic wr_mode(input logic lvl);
    mode_we_i = 1'b1; mode_level_i = lvl; step(); mode_we_i = 1'b0;
  endtask

  task automatic eoi();
    eoi_i = 1'b1; step(); eoi_i = 1'b0;
  endtask

  task automatic ack_first();
    inta_ni = 1'b0; step(); inta_ni = 1'b1; step();
  endtask

  // second strobe, checks vector and valid timing
  task automatic ack_second(input int exp_vec, input string req);
    inta_ni = 1'b0; step();
    chk(vec_valid_o === 1'b1, "R7", int'(vec_valid_o), 1);
    chk(vec_o === 8'(exp_vec), req, int'(vec_o), exp_vec);
    inta_ni = 1'b1; step();
    chk(vec_valid_o === 1'b0, "R7", int'(vec_valid_o), 0);
  endtask

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 7;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk(intr_o === 1'b0, "R1", int'(intr_o), 0);
    chk(vec_valid_o === 1'b0, "R1", int'(vec_valid_o), 0);
    chk(vec_o === 8'h00, "R1", int'(vec_o), 0);
    irq_i = 8'h08; step();
    chk(intr_o === 1'b0, "R1", int'(intr_o), 0);
    irq_i = 8'h00; step();
    wr_mask(8'h00);
    chk(intr_o === 1'b1, "R1", int'(intr_o), 1); // edge mode kept the latch
    ack_first(); ack_second(3, "R1");
    eoi();

    // R2 R8 R9 edge sweep over lines and bases
    for (int i = 0; i < 8; i++) begin
      b = (i * 5 + 3) % 32;
      wr_base(5'(b));
      irq_i = 8'(1 << i); step();
      chk(intr_o === 1'b1, "R2", int'(intr_o), 1);
      ack_first(); ack_second(b * 8 + i, "R8");
      chk(intr_o === 1'b0, "R9", int'(intr_o), 0);
      eoi(); step();
      chk(intr_o === 1'b0, "R2", int'(intr_o), 0);
      irq_i = 8'h00; step();
      irq_i = 8'(1 << i); step();
      chk(intr_o === 1'b1, "R2", int'(intr_o), 1);
      ack_first(); ack_second(b * 8 + i, "R8");
      eoi(); irq_i = 8'h00; step();
    end

    // R3 R5 level sweep over every request pattern
    wr_mode(1'b1);
    wr_base(5'd0);
    for (int p = 1; p < 256; p++) begin
      irq_i = 8'(p); step();
      chk(intr_o === 1'b1, "R3", int'(intr_o), 1);
      ack_first(); ack_second(lowest(8'(p)), "R5");
      eoi();
      irq_i = 8'h00; step();
      chk(intr_o === 1'b0, "R3", int'(intr_o), 0);
    end

    // R4 R11 mask sweep with all lines high
    irq_i = 8'hFF;
    for (int m = 0; m < 256; m++) begin
      wr_mask(8'(m)); step();
      chk(intr_o === (m != 255), "R4", int'(intr_o), int'(m != 255));
      ack_first(); ack_second(lowest(~8'(m)), "R11");
      eoi();
    end
    irq_i = 8'h00; wr_mask(8'h00); step();

    // R7 freeze, R6 blocking, R10 nested end-of-interrupt
    wr_base(5'd9);
    irq_i = 8'h20; step();
    ack_first();
    irq_i = 8'h24; step();
    ack_second(9 * 8 + 5, "R7");
    chk(intr_o === 1'b1, "R6", int'(intr_o), 1);
    irq_i = 8'h60; step();
    chk(intr_o === 1'b0, "R6", int'(intr_o), 0);
    irq_i = 8'h64; step();
    ack_first(); ack_second(9 * 8 + 2, "R6");
    chk(intr_o === 1'b0, "R9", int'(intr_o), 0);
    irq_i = 8'h60; step();
    eoi();
    chk(intr_o === 1'b0, "R10", int'(intr_o), 0);
    eoi();
    chk(intr_o === 1'b1, "R10", int'(intr_o), 1);
    ack_first(); ack_second(9 * 8 + 5, "R10");
    eoi(); irq_i = 8'h00; step();

    // R11 spurious response sets nothing in service
    wr_mode(1'b0);
    wr_mask(8'hFF);
    wr_base(5'd21);
    step();
    ack_first(); ack_second(21 * 8 + 7, "R11");
    wr_mask(8'h00);
    irq_i = 8'h80; step();
    chk(intr_o === 1'b1, "R11", int'(intr_o), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule